// File: doc/BRIEF.md
# Flash Page Dump Framer

This block turns one raw flash page into a self-delimiting byte frame for a byte-wide serial transmitter. A single start pulse delivers a 32-bit page number and the lengths of the two payload sections. The block then pulls page bytes from one valid/ready stream and spare (error-code and metadata) bytes from a second stream. It places them in a fixed order on one valid/ready output stream.

A frame has these fields in this order: an opening marker, the page number with its most significant byte first, the page bytes, the spare bytes, a check byte and a closing marker. The check byte is the two's complement of the 8-bit sum of all bytes from the first page-number byte to the last spare byte. A receiver can therefore add every byte between the markers and expect zero. One register stage sits at the output. A stalled receiver holds that stage, and the stall propagates back to whichever input stream is open at that moment.

Top module: `page_frame_builder`

## Requirements
- R1: After reset, busy_o, out_valid_o, data_ready_o, spare_ready_o and frame_done_o are all low. Whenever busy_o is low, out_valid_o is low.
- R2: The first byte of every frame is the opening marker, parameter SOF_MARK, default 0xA5.
- R3: The next four bytes are the page number captured at the accepted start, most significant byte first.
- R4: Next come exactly data_len_i bytes, taken in order from the page data stream, one per data_valid_i/data_ready_o handshake.
- R5: Next come exactly spare_len_i bytes, taken in order from the spare stream, one per spare_valid_i/spare_ready_o handshake.
- R6: The check byte follows the spare bytes. Modulo 256, it plus every byte from the first page-number byte to the last spare byte adds to zero.
- R7: The last byte is the closing marker, parameter EOF_MARK, default 0x5A. frame_done_o is high for exactly the one cycle in which that byte is accepted, and busy_o is low in the following cycle.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_byte_o does not change in the next cycle.
- R9: While the output is stalled (out_valid_o high, out_ready_i low), data_ready_o and spare_ready_o are low. The two input readies are never high together.
- R10: A start_i pulse while busy_o is high is ignored. The frame in progress keeps its page number and field order, and no second frame follows.
- R11: A section of length zero is left out of the frame entirely, including when both lengths are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame (accepted only when idle) |
| page_num_i | input | 32 | Page number for the frame |
| data_len_i | input | LEN_W | Page byte count |
| spare_len_i | input | LEN_W | Spare byte count |
| data_valid_i | input | 1 | Page byte available |
| data_byte_i | input | 8 | Page byte |
| data_ready_o | output | 1 | Page byte taken this cycle if valid |
| spare_valid_i | input | 1 | Spare byte available |
| spare_byte_i | input | 8 | Spare byte |
| spare_ready_o | output | 1 | Spare byte taken this cycle if valid |
| out_valid_o | output | 1 | Frame byte available |
| out_byte_o | output | 8 | Frame byte |
| out_ready_i | input | 1 | Receiver accepts the frame byte |
| busy_o | output | 1 | Frame in progress |
| frame_done_o | output | 1 | Closing marker accepted this cycle |

## Verification
Frames are built from a table that varies the page number, both section lengths (including zero on either side and on both), the input valid duty and the output ready duty. Continuous ready with continuous valid tests the plain ordering. Gapped valids show whether the framer waits for input instead of inventing bytes. Gapped readies test holding and input back-pressure. A start pulse placed mid-frame shows whether the captured page number and the single closing marker survive. Every received frame is compared with a frame the bench builds on its own, byte by byte, and the summed bytes between the markers must come to zero.

// File: rtl/frame_pkg.sv
package frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SOF, ST_PNUM, ST_DATA, ST_SPARE, ST_CSUM, ST_EOF, ST_DRAIN
  } fstate_t;

  // running modulo-256 sum
  function automatic logic [7:0] csum_add(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  // value that brings the running sum back to zero
  function automatic logic [7:0] csum_close(input logic [7:0] acc);
    return 8'(~acc + 8'd1);
  endfunction

  // page number byte, index 0 is the most significant
  function automatic logic [7:0] pnum_byte(input logic [31:0] page, input logic [1:0] idx);
    return page[8*(3-idx) +: 8];
  endfunction

  // state after the page number, skipping empty sections
  function automatic fstate_t after_pnum(input logic data_empty, input logic spare_empty);
    if (!data_empty)       return ST_DATA;
    else if (!spare_empty) return ST_SPARE;
    else                   return ST_CSUM;
  endfunction

endpackage

// File: rtl/frame_seq.sv
module frame_seq
  import frame_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] data_len_i,
  input  logic [LEN_W-1:0] spare_len_i,
  input  logic             room_i,
  input  logic             data_valid_i,
  input  logic             spare_valid_i,
  input  logic             eof_taken_i,
  output fstate_t          state_o,
  output logic [LEN_W-1:0] cnt_o,
  output logic             start_acc_o,
  output logic             load_o,
  output logic             data_ready_o,
  output logic             spare_ready_o
);

  localparam logic [LEN_W-1:0] PNUM_LAST = LEN_W'(3);

  fstate_t          state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] dlen_q;
  logic [LEN_W-1:0] slen_q;

  assign start_acc_o   = start_i && (state_q == ST_IDLE);
  assign data_ready_o  = room_i && (state_q == ST_DATA);
  assign spare_ready_o = room_i && (state_q == ST_SPARE);

  always_comb begin
    unique case (state_q)
      ST_SOF, ST_PNUM, ST_CSUM, ST_EOF: load_o = room_i;
      ST_DATA:  load_o = data_ready_o && data_valid_i;
      ST_SPARE: load_o = spare_ready_o && spare_valid_i;
      default:  load_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dlen_q  <= '0;
      slen_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          dlen_q  <= data_len_i;
          slen_q  <= spare_len_i;
          cnt_q   <= '0;
          state_q <= ST_SOF;
        end
        ST_SOF: if (load_o) state_q <= ST_PNUM;
        ST_PNUM: if (load_o) begin
          if (cnt_q == PNUM_LAST) begin
            cnt_q   <= '0;
            state_q <= after_pnum(dlen_q == '0, slen_q == '0);
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: if (load_o) begin
          if (cnt_q == dlen_q - 1'b1) begin
            cnt_q   <= '0;
            state_q <= (slen_q == '0) ? ST_CSUM : ST_SPARE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_SPARE: if (load_o) begin
          if (cnt_q == slen_q - 1'b1) begin
            cnt_q   <= '0;
            state_q <= ST_CSUM;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_CSUM:  if (load_o) state_q <= ST_EOF;
        ST_EOF:   if (load_o) state_q <= ST_DRAIN;
        ST_DRAIN: if (eof_taken_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;

  AST_ONE_SECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_ready_o && spare_ready_o)); // R9

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_SOF) |=> state_q != ST_SOF); // R10

endmodule

// File: rtl/frame_csum.sv
module frame_csum
  import frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       add_i,
  input  logic [7:0] byte_i,
  output logic [7:0] check_o
);

  logic [7:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) acc_q <= '0;
    else if (add_i)        acc_q <= csum_add(acc_q, byte_i);
  end

  assign check_o = csum_close(acc_q);

endmodule

// File: rtl/page_frame_builder.sv
module page_frame_builder
  import frame_pkg::*;
#(
  parameter int         LEN_W    = 16,
  parameter logic [7:0] SOF_MARK = 8'hA5,
  parameter logic [7:0] EOF_MARK = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [31:0]      page_num_i,
  input  logic [LEN_W-1:0] data_len_i,
  input  logic [LEN_W-1:0] spare_len_i,
  input  logic             data_valid_i,
  input  logic [7:0]       data_byte_i,
  output logic             data_ready_o,
  input  logic             spare_valid_i,
  input  logic [7:0]       spare_byte_i,
  output logic             spare_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_byte_o,
  input  logic             out_ready_i,
  output logic             busy_o,
  output logic             frame_done_o
);

  fstate_t          state;
  logic [LEN_W-1:0] cnt;
  logic             start_acc;
  logic             load;
  logic             room;
  logic [7:0]       check_byte;
  logic [7:0]       next_byte;
  logic             summed;

  logic [31:0]      page_q;
  logic             ov_q;
  logic [7:0]       ob_q;
  logic             last_q;

  assign room         = !ov_q || out_ready_i;
  assign frame_done_o = ov_q && out_ready_i && last_q;
  assign summed       = load && (state == ST_PNUM || state == ST_DATA || state == ST_SPARE);

  frame_seq #(.LEN_W(LEN_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .data_len_i    (data_len_i),
    .spare_len_i   (spare_len_i),
    .room_i        (room),
    .data_valid_i  (data_valid_i),
    .spare_valid_i (spare_valid_i),
    .eof_taken_i   (frame_done_o),
    .state_o       (state),
    .cnt_o         (cnt),
    .start_acc_o   (start_acc),
    .load_o        (load),
    .data_ready_o  (data_ready_o),
    .spare_ready_o (spare_ready_o)
  );

  frame_csum u_csum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_acc),
    .add_i   (summed),
    .byte_i  (next_byte),
    .check_o (check_byte)
  );

  always_comb begin
    unique case (state)
      ST_SOF:   next_byte = SOF_MARK;
      ST_PNUM:  next_byte = pnum_byte(page_q, cnt[1:0]);
      ST_DATA:  next_byte = data_byte_i;
      ST_SPARE: next_byte = spare_byte_i;
      ST_CSUM:  next_byte = check_byte;
      ST_EOF:   next_byte = EOF_MARK;
      default:  next_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      ov_q   <= 1'b0;
      ob_q   <= '0;
      last_q <= 1'b0;
    end else begin
      if (start_acc) page_q <= page_num_i;
      if (load) begin
        ov_q   <= 1'b1;
        ob_q   <= next_byte;
        last_q <= (state == ST_EOF);
      end else if (out_ready_i) begin
        ov_q   <= 1'b0;
      end
    end
  end

  assign out_valid_o = ov_q;
  assign out_byte_o  = ob_q;
  assign busy_o      = (state != ST_IDLE);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_byte_o))); // R8

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |-> (!data_ready_o && !spare_ready_o)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !out_valid_o); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> (!frame_done_o && !busy_o)); // R7

endmodule

// File: tb/sim_page_frame_builder.sv
module sim_page_frame_builder;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [31:0] page;
    logic [15:0] dlen;
    logic [15:0] slen;
    logic [7:0]  seed;
    logic [7:0]  vmod;
    logic [7:0]  rmod;
    logic        restart;
  } vec_t;

  // page, data len, spare len, seed, valid gap modulus, ready gap modulus, mid-frame start
  localparam vec_t VECS [NVEC] = '{
    '{32'h1234_5678, 16'd8,  16'd4, 8'h11, 8'd0, 8'd0, 1'b0},
    '{32'hDEAD_BEEF, 16'd16, 16'd6, 8'h40, 8'd3, 8'd0, 1'b0},
    '{32'h0000_0001, 16'd10, 16'd3, 8'h7E, 8'd0, 8'd2, 1'b0},
    '{32'hFFFF_FF00, 16'd12, 16'd5, 8'hC3, 8'd4, 8'd3, 1'b0},
    '{32'hA5A5_5A5A, 16'd0,  16'd5, 8'h09, 8'd0, 8'd3, 1'b0},
    '{32'h8000_0000, 16'd7,  16'd0, 8'hF0, 8'd2, 8'd0, 1'b0},
    '{32'h0BAD_F00D, 16'd0,  16'd0, 8'h00, 8'd0, 8'd2, 1'b0},
    '{32'h7654_3210, 16'd9,  16'd4, 8'h5C, 8'd3, 8'd4, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [31:0]   page_num_i = '0;
  logic [LW-1:0] data_len_i = '0;
  logic [LW-1:0] spare_len_i = '0;
  logic          data_valid_i = 1'b0;
  logic [7:0]    data_byte_i = '0;
  logic          data_ready_o;
  logic          spare_valid_i = 1'b0;
  logic [7:0]    spare_byte_i = '0;
  logic          spare_ready_o;
  logic          out_valid_o;
  logic [7:0]    out_byte_o;
  logic          out_ready_i = 1'b0;
  logic          busy_o;
  logic          frame_done_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_frame_builder #(.LEN_W(LW)) u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 13);
  endfunction

  function automatic logic [7:0] sbyte(input logic [7:0] seed, input int i);
    return (seed ^ 8'h3C) + 8'(i * 5);
  endfunction

  function automatic string tag(input int pos, input int d, input int s);
    int total = 7 + d + s;
    if (pos == 0)              return "R2";
    else if (pos < 5)          return "R3 (R10 when restarted)";
    else if (pos < 5 + d)      return "R4";
    else if (pos < 5 + d + s)  return "R5";
    else if (pos == total - 2) return "R6";
    else                       return "R7";
  endfunction

  task automatic run_frame(input vec_t v);
    logic [7:0] expb [64];
    logic [7:0] gotb [64];
    int d = int'(v.dlen);
    int s = int'(v.slen);
    int total = 7 + d + s;
    int got = 0, didx = 0, sidx = 0, dn = 0, cyc = 0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_byte = '0;
    logic [7:0] sum = '0;

    // independent model of the frame
    expb[0] = 8'hA5;
    for (int k = 0; k < 4; k++) expb[1+k] = v.page[31-8*k -: 8];
    for (int k = 0; k < d; k++) expb[5+k] = dbyte(v.seed, k);
    for (int k = 0; k < s; k++) expb[5+d+k] = sbyte(v.seed, k);
    for (int k = 1; k < 5 + d + s; k++) sum = sum + expb[k];
    expb[total-2] = 8'(0 - sum);
    expb[total-1] = 8'h5A;

    data_len_i  = v.dlen;
    spare_len_i = v.slen;
    while (got < total && cyc < 3000) begin
      @(negedge clk);
      start_i      = (cyc == 0) || (v.restart && cyc == 6);
      page_num_i   = (cyc == 0) ? v.page : ~v.page;
      data_valid_i = (didx < d) && (v.vmod == 0 || (cyc % int'(v.vmod)) != 0);
      data_byte_i  = dbyte(v.seed, didx);
      spare_valid_i = (sidx < s) && (v.vmod == 0 || (cyc % int'(v.vmod)) != 1);
      spare_byte_i = sbyte(v.seed, sidx);
      out_ready_i  = (v.rmod == 0) || (cyc % int'(v.rmod)) != 0;
      #1;
      if (prev_stall)
        check(out_valid_o && out_byte_o == prev_byte, "R8 hold", int'(out_byte_o), int'(prev_byte));
      if (out_valid_o && !out_ready_i)
        check(!data_ready_o && !spare_ready_o, "R9 backpressure",
              int'({data_ready_o, spare_ready_o}), 0);
      if (out_valid_o && out_ready_i) begin
        check(out_byte_o == expb[got], tag(got, d, s), int'(out_byte_o), int'(expb[got]));
        gotb[got] = out_byte_o;
        got++;
      end
      if (frame_done_o) dn++;
      if (data_valid_i && data_ready_o) didx++;
      if (spare_valid_i && spare_ready_o) sidx++;
      prev_stall = out_valid_o && !out_ready_i;
      prev_byte  = out_byte_o;
      cyc++;
    end
    start_i = 1'b0;
    check(got == total, "R4/R5/R11 frame length", got, total);
    check(didx == d && sidx == s, "R4/R5/R11 input bytes taken", didx * 256 + sidx, d * 256 + s);
    check(dn == 1, "R7 done pulse count", dn, 1);
    sum = '0;
    for (int k = 1; k < got - 1; k++) sum = sum + gotb[k];
    check(got != total || sum == 8'h00, "R6 zero sum", int'(sum), 0);
    @(negedge clk);
    #1;
    check(!busy_o && !out_valid_o, "R7/R10 idle after one frame",
          int'({busy_o, out_valid_o}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state (R1)
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid_o && !busy_o && !frame_done_o && !data_ready_o && !spare_ready_o,
          "R1 in reset", int'({out_valid_o, busy_o, frame_done_o, data_ready_o, spare_ready_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready_i = 1'b1;
    data_valid_i = 1'b1;
    spare_valid_i = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid_o && !busy_o && !data_ready_o && !spare_ready_o,
          "R1 idle after reset", int'({out_valid_o, busy_o, data_ready_o, spare_ready_o}), 0);
    data_valid_i = 1'b0;
    spare_valid_i = 1'b0;

    foreach (VECS[i]) run_frame(VECS[i]);

    // R11: back-to-back zero-length frame with ready held low first, then released
    run_frame('{32'h0102_0304, 16'd0, 16'd0, 8'h00, 8'd0, 8'd5, 1'b1});

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule